// File: doc/BRIEF.md
# Precoded Partial-Response Symbol Encoder

This block produces the noiseless sample stream of a binary-input partial-response channel. A recursive modulo-2 precoder and an integer-tap channel polynomial are folded into one state machine. One data bit is accepted per cycle under a valid strobe. The bit is optionally precoded, shifted into a short channel history, and turned into a small signed multilevel sample. Each sample is registered and comes out one cycle after its bit, together with the resulting state index.

Two channel variants are chosen at elaboration time. The first is a two-state first-order difference channel, y = x(k) − x(k−1). The second is an eight-state third-order channel, y = x(k) + x(k−1) − x(k−2) − x(k−3). In both, a stored channel input of 1 counts as +1 and a 0 counts as 0. The precoder can be switched in or out. When it is in, it is the feedback modulo-2 filter matched to the channel, so that each noiseless sample fixes its input bit on its own.

A block starts with a start pulse, which clears the history. After the last data bit, a flush request starts a termination phase. That phase feeds zeros into the channel for as many cycles as the channel degree, so a frame always ends in the zero state with the data length plus the degree samples emitted. A done flag marks the last one. A test bench or a recording-channel model uses the block to generate reference symbols.

Top module: `pr_symbol_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sample_valid_o and done_o are 0, state_o is all zeros and sample_o is 0.
- R2: A data bit accepted at a clock edge makes sample_valid_o high in the cycle after that edge, with its sample on sample_o. Without an accepted bit or a termination step, sample_valid_o is 0.
- R3: With CHAN_DEG = 3, sample_o (3-bit two's complement) equals x(k) + x(k−1) − x(k−2) − x(k−3). Here x(k) is the channel input of the current step and x(k−i) is its value i steps earlier. The sample always lies in −2..+2.
- R4: With CHAN_DEG = 1, sample_o equals x(k) − x(k−1) and lies in −1..+1.
- R5: With PRECODE_EN = 1, the channel input is x(k) = b(k) XOR x(k−1) XOR … XOR x(k−CHAN_DEG). With PRECODE_EN = 0 it is x(k) = b(k).
- R6: state_o bit i holds x(k−i) of the latest step, so bit 0 is the newest channel input. state_o changes only on a step or a start, and a step shifts the older bits up by one.
- R7: A flush_i accepted in the data phase produces exactly CHAN_DEG further samples on consecutive cycles, each with the channel input forced to 0. done_o is high only with the last of them, and state_o is zero afterwards.
- R8: After termination completes, bit_valid_i and flush_i have no effect (no sample, state unchanged) until start_i.
- R9: start_i takes priority over everything else. It clears state_o, emits no sample and returns the block to the data phase. flush_i takes priority over bit_valid_i in the same cycle, and that bit is dropped.
- R10: With PRECODE_EN = 1, bit 0 of every data-bit sample equals the input bit it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new block; clears the channel state |
| flush_i | input | 1 | End of data; start the termination phase |
| bit_valid_i | input | 1 | Data bit strobe |
| bit_i | input | 1 | Data bit |
| sample_valid_o | output | 1 | A new sample is on sample_o |
| sample_o | output | SAMPLE_W | Signed channel sample, two's complement |
| state_o | output | CHAN_DEG | Channel input history, bit 0 newest |
| done_o | output | 1 | Last termination sample of the block |

## Verification
The assertions check the following on every cycle:
- each sample stays inside the alphabet of its channel;
- the state moves by a one-bit shift or not at all;
- the done flag comes alone, with a zero state;
- a start leaves no sample behind;
- with the precoder in, each data sample's low bit reproduces its input bit.

The exact sample values, the precoder recursion over long histories, the count of termination samples and the inertness of the block after termination depend on a whole sequence of inputs. Only the bench scenarios show those. The bench drives all four channel/precoder variants side by side against a reference model.

// File: rtl/pr_enc_pkg.sv
package pr_enc_pkg;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_FLUSH = 2'd1,
    PH_IDLE  = 2'd2
  } pr_phase_e;

  localparam int unsigned PR_SAMPLE_W_DEF = 3;

endpackage

// File: rtl/pr_seq_ctrl.sv
module pr_seq_ctrl
  import pr_enc_pkg::*;
#(
  parameter int unsigned CHAN_DEG = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic flush_i,
  input  logic bit_valid_i,
  output logic shift_en_o,
  output logic force_zero_o,
  output logic last_step_o,
  output logic clear_o
);

  localparam int unsigned CNT_W = $clog2(CHAN_DEG + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHAN_DEG - 1);

  pr_phase_e        ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d         = ph_q;
    cnt_d        = cnt_q;
    shift_en_o   = 1'b0;
    force_zero_o = 1'b0;
    last_step_o  = 1'b0;
    clear_o      = start_i;
    if (start_i) begin
      ph_d  = PH_DATA;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_DATA: begin
          if (flush_i) begin
            ph_d  = PH_FLUSH;
            cnt_d = '0;
          end else begin
            shift_en_o = bit_valid_i;
          end
        end
        PH_FLUSH: begin
          shift_en_o   = 1'b1;
          force_zero_o = 1'b1;
          if (cnt_q == LAST_CNT) begin
            last_step_o = 1'b1;
            ph_d        = PH_IDLE;
            cnt_d       = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_IDLE: begin
          ph_d = PH_IDLE;
        end
        default: begin
          ph_d  = PH_DATA;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_DATA;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pr_precoder.sv
module pr_precoder #(
  parameter int unsigned ST_W       = 3,
  parameter bit          PRECODE_EN = 1'b1
) (
  input  logic            bit_i,
  input  logic [ST_W-1:0] hist_i,
  output logic            x_o
);

  generate
    if (PRECODE_EN) begin : g_feedback
      assign x_o = bit_i ^ (^hist_i);
    end else begin : g_bypass
      assign x_o = bit_i;
    end
  endgenerate

endmodule

// File: rtl/pr_tap_sum.sv
module pr_tap_sum #(
  parameter int unsigned CHAN_DEG = 3,
  parameter int unsigned SAMPLE_W = 3
) (
  input  logic                       x_i,
  input  logic [CHAN_DEG-1:0]        hist_i,
  output logic signed [SAMPLE_W-1:0] y_o
);

  localparam int unsigned PAD = SAMPLE_W - 1;

  logic signed [SAMPLE_W-1:0] t0;
  assign t0 = $signed({{PAD{1'b0}}, x_i});

  generate
    if (CHAN_DEG == 3) begin : g_third
      logic signed [SAMPLE_W-1:0] t1, t2, t3;
      assign t1  = $signed({{PAD{1'b0}}, hist_i[0]});
      assign t2  = $signed({{PAD{1'b0}}, hist_i[1]});
      assign t3  = $signed({{PAD{1'b0}}, hist_i[2]});
      assign y_o = t0 + t1 - t2 - t3;
    end else begin : g_first
      logic signed [SAMPLE_W-1:0] t1;
      assign t1  = $signed({{PAD{1'b0}}, hist_i[0]});
      assign y_o = t0 - t1;
    end
  endgenerate

endmodule

// File: rtl/pr_symbol_encoder.sv
module pr_symbol_encoder
  import pr_enc_pkg::*;
#(
  parameter int unsigned CHAN_DEG   = 3,
  parameter bit          PRECODE_EN = 1'b1,
  parameter int unsigned SAMPLE_W   = PR_SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                flush_i,
  input  logic                bit_valid_i,
  input  logic                bit_i,
  output logic                sample_valid_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [CHAN_DEG-1:0] state_o,
  output logic                done_o
);

  localparam int unsigned ST_W = CHAN_DEG;

  logic                       shift_en, force_zero, last_step, clear_state;
  logic                       pre_out, chan_in;
  logic [ST_W-1:0]            hist_q, hist_d, hist_shift;
  logic signed [SAMPLE_W-1:0] tap_y;
  logic [SAMPLE_W-1:0]        sample_q, sample_d;
  logic                       valid_q, valid_d, done_q, done_d;

  pr_seq_ctrl #(.CHAN_DEG(CHAN_DEG)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .flush_i      (flush_i),
    .bit_valid_i  (bit_valid_i),
    .shift_en_o   (shift_en),
    .force_zero_o (force_zero),
    .last_step_o  (last_step),
    .clear_o      (clear_state)
  );

  pr_precoder #(.ST_W(ST_W), .PRECODE_EN(PRECODE_EN)) u_pre (
    .bit_i  (bit_i),
    .hist_i (hist_q),
    .x_o    (pre_out)
  );

  assign chan_in = force_zero ? 1'b0 : pre_out;

  pr_tap_sum #(.CHAN_DEG(CHAN_DEG), .SAMPLE_W(SAMPLE_W)) u_taps (
    .x_i    (chan_in),
    .hist_i (hist_q),
    .y_o    (tap_y)
  );

  generate
    if (ST_W == 1) begin : g_hist1
      assign hist_shift = chan_in;
    end else begin : g_histn
      assign hist_shift = {hist_q[ST_W-2:0], chan_in};
    end
  endgenerate

  always_comb begin
    hist_d   = hist_q;
    sample_d = sample_q;
    valid_d  = 1'b0;
    done_d   = 1'b0;
    if (clear_state) begin
      hist_d = '0;
    end else if (shift_en) begin
      hist_d   = hist_shift;
      sample_d = tap_y;
      valid_d  = 1'b1;
      done_d   = last_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      sample_q <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      if (shift_en && !clear_state) begin
        sample_q <= sample_d;
      end
    end
  end

  assign sample_valid_o = valid_q;
  assign sample_o       = sample_q;
  assign state_o        = hist_q;
  assign done_o         = done_q;

endmodule

// File: rtl/pr_symbol_encoder_chk.sv
module pr_symbol_encoder_chk #(
  parameter int unsigned CHAN_DEG   = 3,
  parameter bit          PRECODE_EN = 1'b1,
  parameter int unsigned SAMPLE_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                bit_i,
  input logic                force_zero,
  input logic                sample_valid_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic [CHAN_DEG-1:0] state_o,
  input logic                done_o
);

  localparam int MAX_MAG = (CHAN_DEG == 3) ? 2 : 1;

  // R3 / R4: the sample stays inside the channel alphabet
  p_alphabet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |-> ($signed(sample_o) <= MAX_MAG && $signed(sample_o) >= -MAX_MAG));

  // R9: a start leaves a cleared state and no sample
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!sample_valid_o && !done_o && state_o == '0));

  // R7: done only with a valid sample and a zero state
  p_done_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sample_valid_o && state_o == '0));

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: a termination step pushes a zero into the history
  p_flush_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero |=> (sample_valid_o && !state_o[0]));

  // R6: no step and no start means the state holds
  p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid_o && !$past(start_i)) |-> $stable(state_o));

  generate
    if (CHAN_DEG > 1) begin : g_shift
      // R6: a step shifts the older history up by one
      p_state_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_o && !$past(start_i)) |->
          (state_o[CHAN_DEG-1:1] == $past(state_o[CHAN_DEG-2:0])));
    end
    if (PRECODE_EN) begin : g_parity
      // R10: precoded data sample parity reproduces the input bit
      p_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_o && !$past(force_zero)) |-> (sample_o[0] == $past(bit_i)));
    end
  endgenerate

endmodule

bind pr_symbol_encoder pr_symbol_encoder_chk #(
  .CHAN_DEG   (CHAN_DEG),
  .PRECODE_EN (PRECODE_EN),
  .SAMPLE_W   (SAMPLE_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .bit_i          (bit_i),
  .force_zero     (force_zero),
  .sample_valid_o (sample_valid_o),
  .sample_o       (sample_o),
  .state_o        (state_o),
  .done_o         (done_o)
);

// File: tb/tb_pr_symbol_encoder.sv
module tb_pr_symbol_encoder;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, flush_i, bit_valid_i, bit_i;
  always #5 clk = ~clk;

  // config 0: deg3 precoded, 1: deg3 plain, 2: deg1 precoded, 3: deg1 plain
  logic       v0, v1, v2, v3, d0, d1, d2, d3;
  logic [2:0] s0, s1, s2, s3, st0, st1;
  logic [0:0] st2, st3;

  pr_symbol_encoder #(.CHAN_DEG(3), .PRECODE_EN(1'b1), .SAMPLE_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_i(flush_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i),
    .sample_valid_o(v0), .sample_o(s0), .state_o(st0), .done_o(d0));
  pr_symbol_encoder #(.CHAN_DEG(3), .PRECODE_EN(1'b0), .SAMPLE_W(3)) dut_b (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_i(flush_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i),
    .sample_valid_o(v1), .sample_o(s1), .state_o(st1), .done_o(d1));
  pr_symbol_encoder #(.CHAN_DEG(1), .PRECODE_EN(1'b1), .SAMPLE_W(3)) dut_c (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_i(flush_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i),
    .sample_valid_o(v2), .sample_o(s2), .state_o(st2), .done_o(d2));
  pr_symbol_encoder #(.CHAN_DEG(1), .PRECODE_EN(1'b0), .SAMPLE_W(3)) dut_d (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_i(flush_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i),
    .sample_valid_o(v3), .sample_o(s3), .state_o(st3), .done_o(d3));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state per config
  int         m_deg[4] = '{3, 3, 1, 1};
  bit         m_pre[4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  int         m_ph[4];   // 0 data, 1 flush, 2 idle
  int         m_cnt[4];
  logic [2:0] m_hist[4];
  bit         e_v[4], e_d[4], e_bitstep[4];
  int         e_y[4];
  string      e_vtag[4];

  function automatic logic [2:0] mask_of(int c);
    return (m_deg[c] == 3) ? 3'b111 : 3'b001;
  endfunction

  function automatic int tap_ref(int c, bit x);
    logic [2:0] h = m_hist[c];
    if (m_deg[c] == 3) return int'(x) + int'(h[0]) - int'(h[1]) - int'(h[2]);
    return int'(x) - int'(h[0]);
  endfunction

  function automatic void model_step(int c, bit st, bit fl, bit bv, bit b);
    bit x;
    e_v[c] = 1'b0; e_d[c] = 1'b0; e_bitstep[c] = 1'b0;
    if (st) begin
      m_hist[c] = '0; m_ph[c] = 0; m_cnt[c] = 0; e_vtag[c] = "R9";
    end else if (m_ph[c] == 0) begin
      if (fl) begin
        m_ph[c] = 1; m_cnt[c] = 0; e_vtag[c] = "R9";
      end else if (bv) begin
        x = m_pre[c] ? (b ^ (^(m_hist[c] & mask_of(c)))) : b;
        e_y[c] = tap_ref(c, x);
        m_hist[c] = ((m_hist[c] << 1) | {2'b00, x}) & mask_of(c);
        e_v[c] = 1'b1; e_bitstep[c] = 1'b1; e_vtag[c] = "R2";
      end else begin
        e_vtag[c] = "R2";
      end
    end else if (m_ph[c] == 1) begin
      e_y[c] = tap_ref(c, 1'b0);
      m_hist[c] = (m_hist[c] << 1) & mask_of(c);
      e_v[c] = 1'b1; e_vtag[c] = "R7";
      if (m_cnt[c] == m_deg[c] - 1) begin
        e_d[c] = 1'b1; m_ph[c] = 2;
      end else begin
        m_cnt[c]++;
      end
    end else begin
      e_vtag[c] = "R8";
    end
  endfunction

  function automatic void get_obs(int c, output bit v, output bit d,
                                  output int y, output logic [2:0] st);
    case (c)
      0: begin v = v0; d = d0; y = int'($signed(s0)); st = st0; end
      1: begin v = v1; d = d1; y = int'($signed(s1)); st = st1; end
      2: begin v = v2; d = d2; y = int'($signed(s2)); st = {2'b00, st2}; end
      default: begin v = v3; d = d3; y = int'($signed(s3)); st = {2'b00, st3}; end
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp, int c);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cfg%0d t=%0t actual=%0d expected=%0d", tag, c, $time, act, exp);
    end
  endtask

  task automatic cyc(bit st, bit fl, bit bv, bit b);
    @(negedge clk);
    start_i = st; flush_i = fl; bit_valid_i = bv; bit_i = b;
    for (int c = 0; c < 4; c++) model_step(c, st, fl, bv, b);
    @(posedge clk);
    #1;
    for (int c = 0; c < 4; c++) begin
      bit v, d; int y; logic [2:0] s;
      get_obs(c, v, d, y, s);
      chk(e_vtag[c], int'(v), int'(e_v[c]), c);
      chk("R7 done", int'(d), int'(e_d[c]), c);
      chk("R6 state", int'(s), int'(m_hist[c]), c);
      if (e_v[c]) begin
        if (m_deg[c] == 3) chk(m_pre[c] ? "R3/R5 sample" : "R3 sample", y, e_y[c], c);
        else               chk(m_pre[c] ? "R4/R5 sample" : "R4 sample", y, e_y[c], c);
      end
      if (e_bitstep[c] && m_pre[c]) chk("R10 parity", y & 1, int'(b), c);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired t=%0t actual=running expected=finished", $time);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; flush_i = 1'b0; bit_valid_i = 1'b0; bit_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      m_ph[c] = 0; m_cnt[c] = 0; m_hist[c] = '0; e_y[c] = 0; e_vtag[c] = "R1";
    end
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < 4; c++) begin
      bit v, d; int y; logic [2:0] s;
      get_obs(c, v, d, y, s);
      chk("R1 valid", int'(v), 0, c);
      chk("R1 done", int'(d), 0, c);
      chk("R1 state", int'(s), 0, c);
      chk("R1 sample", y, 0, c);
    end
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);

    // directed: start, run of ones, flush with a competing bit
    cyc(1, 0, 1, 1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 1, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1);
    // ignored after termination
    cyc(0, 1, 1, 0);
    cyc(0, 0, 1, 1);
    // restart, alternating bits, start during termination
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, i[0]);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(1, 1, 1, 1);
    cyc(0, 0, 1, 1);
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      bit st = ($urandom % 40) == 0;
      bit fl = ($urandom % 20) == 0;
      bit bv = ($urandom % 4) != 0;
      bit b  = $urandom % 2;
      cyc(st, fl, bv, b);
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule